// File: doc/BRIEF.md
# TLB Address Translation Unit

This unit turns the virtual address of a load or store into a physical address. The upper twenty bits of the address select a page and the lower twelve bits locate a byte inside that page. The page number is looked up in a four-entry, fully associative cache of page table entries. On a miss, the unit reads the entry from a single-level table in memory. The table starts at a base address supplied on an input, and each entry occupies four bytes. A valid entry that has been fetched is placed in the cache, and the slots are reused in round-robin order.

The unit also keeps two status bits current in every entry it uses. Any access that succeeds marks the entry as referenced. A store that succeeds also marks it dirty. When either bit changes, the new entry is written back to memory before the request completes. The unit does not translate an access to a page that is not resident; it reports a page fault. It also does not translate a store to a page that is not writable; it reports a protection fault. The operating system handles both faults and then retries the access. Requests use a ready/valid start and a one-cycle completion pulse, and only one request is in flight at a time.

Top module: `addr_xlate_unit`

## Requirements
- R1: On a completion without a fault, `done_paddr` equals the frame field of the entry (entry bits 31:12) followed by the unchanged low twelve bits of `req_vaddr`. On a fault, `done_paddr` reads zero.
- R2: A page number held in the cache causes no memory read. A page number not held in the cache causes exactly one read, at `pt_base + vaddr[31:12]*4`.
- R3: If the fetched entry has bit 0 (valid) clear, the request completes with `fault_page` and nothing is written. The entry is not cached, so a retry of the same address reads the table again.
- R4: Every access that completes without a fault leaves the entry with bit 2 (referenced) set, both in the cache and in memory.
- R5: A store that completes without a fault leaves bit 3 (dirty) set. A load never changes bit 3.
- R6: A store to an entry with bit 1 (writable) clear completes with `fault_wprot`, changes no bit and writes nothing.
- R7: When an access changes bit 2 or bit 3, exactly one memory write of the whole 32-bit entry goes to that entry's table address before `done`. When neither bit changes, no write is issued.
- R8: The cache holds four entries. Fetched valid entries fill the slots in round-robin order, whatever hits occur in between, so the fifth distinct page fetched displaces the first.
- R9: A one-cycle pulse on `flush` invalidates every cached entry. The next access to any page then reads the table again.
- R10: `req_ready` is high only while the unit is idle. `done` is a single-cycle pulse that carries at most one fault flag. A memory request holds its address and direction until `mem_ack`.
- R11: After reset the cache is empty, `req_ready` is high, and `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all cached entries |
| pt_base | input | 32 | Byte address of the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 for a store, 0 for a load |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Physical address, valid with `done` |
| fault_page | output | 1 | Page not resident, valid with `done` |
| fault_wprot | output | 1 | Store to a read-only page, valid with `done` |
| mem_req | output | 1 | Memory access request for a table entry |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_wdata | output | 32 | Entry value being written back |
| mem_ack | input | 1 | One-cycle acknowledge of the memory access |
| mem_rdata | input | 32 | Entry read from memory, valid with `mem_ack` |

## Verification
The assertions assume the following of the environment:
- `mem_ack` arrives only while `mem_req` is high, and lasts one cycle.
- `mem_rdata` is valid during that cycle.
- `pt_base` does not change while a request is in progress.
- `flush` is pulsed only while `req_ready` is high.

The bench meets these assumptions as follows:
- Its memory model raises the acknowledge on the falling edge after it sees a request, and drops it on the next falling edge.
- It holds one table base for the whole run.
- It issues its flush pulse only between requests, after the previous `done`.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PTE_W  = 32;
  localparam int FRM_W  = PTE_W - OFF_W;
  localparam int SPARE_W = OFF_W - 4;

  typedef struct packed {
    logic [FRM_W-1:0]   frame;
    logic [SPARE_W-1:0] spare;
    logic               dirty;
    logic               refd;
    logic               wr;
    logic               vld;
  } pte_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_FETCH, ST_CHECK, ST_WBACK, ST_RESP
  } xstate_t;

  function automatic logic [VA_W-1:0] entry_addr(input logic [VA_W-1:0] base,
                                                 input logic [VPN_W-1:0] vpn);
    return base + {{(VA_W-VPN_W-2){1'b0}}, vpn, 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] join_paddr(input logic [FRM_W-1:0] frm,
                                                 input logic [OFF_W-1:0] off);
    return {frm, off};
  endfunction

  function automatic pte_t touch_entry(input pte_t p, input logic is_st);
    pte_t n;
    n = p;
    n.refd = 1'b1;
    if (is_st) n.dirty = 1'b1;
    return n;
  endfunction
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xlate_pkg::*;
#(
  parameter int TLB_N = 4,
  localparam int IW = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [IW-1:0]    lk_idx,
  output pte_t             lk_pte,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  pte_t             ins_pte,
  output logic [IW-1:0]    ins_idx,
  input  logic             upd_en,
  input  logic [IW-1:0]    upd_idx,
  input  pte_t             upd_pte,
  output logic [TLB_N-1:0] live
);
  logic [TLB_N-1:0] hit_vec;
  pte_t             pte_arr [TLB_N];
  logic [IW-1:0]    ptr_q;

  for (genvar i = 0; i < TLB_N; i++) begin : g_ent
    logic             vld_q;
    logic [VPN_W-1:0] tag_q;
    pte_t             pte_q;
    wire              sel_ins = ins_en && (ptr_q == IW'(i));
    wire              sel_upd = upd_en && (upd_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        tag_q <= '0;
        pte_q <= '0;
      end else begin
        if (flush)        vld_q <= 1'b0;
        else if (sel_ins) vld_q <= 1'b1;
        if (sel_ins) begin
          tag_q <= ins_vpn;
          pte_q <= ins_pte;
        end else if (sel_upd) begin
          pte_q <= upd_pte;
        end
      end
    end

    assign hit_vec[i] = vld_q && (tag_q == lk_vpn);
    assign pte_arr[i] = pte_q;
    assign live[i]    = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ins_en) ptr_q <= (ptr_q == IW'(TLB_N-1)) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    lk_hit = |hit_vec;
    lk_idx = '0;
    lk_pte = '0;
    for (int i = 0; i < TLB_N; i++) begin
      if (hit_vec[i]) begin
        lk_idx = IW'(i);
        lk_pte = pte_arr[i];
      end
    end
  end

  assign ins_idx = ptr_q;
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int TLB_N = 4,
  localparam int IW = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  pt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  output logic             done,
  output logic [VA_W-1:0]  done_paddr,
  output logic             fault_page,
  output logic             fault_wprot,
  output logic             mem_req,
  output logic             mem_we,
  output logic [VA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_hit,
  input  logic [IW-1:0]    lk_idx,
  input  pte_t             lk_pte,
  output logic             ins_en,
  output logic [VPN_W-1:0] ins_vpn,
  output pte_t             ins_pte,
  input  logic [IW-1:0]    ins_idx,
  output logic             upd_en,
  output logic [IW-1:0]    upd_idx,
  output pte_t             upd_pte,
  output logic             st_busy
);
  xstate_t          state_q;
  logic [VA_W-1:0]  va_q;
  logic             st_q;
  pte_t             pte_q;
  logic [IW-1:0]    idx_q;
  logic [VA_W-1:0]  pa_q;
  logic             fpg_q, fwp_q;

  pte_t             rd_pte;
  pte_t             new_pte;
  logic             bits_change;
  logic             deny_page, deny_wr;

  assign rd_pte      = pte_t'(mem_rdata);
  assign new_pte     = touch_entry(pte_q, st_q);
  assign bits_change = (new_pte != pte_q);
  assign deny_page   = !pte_q.vld;
  assign deny_wr     = pte_q.vld && st_q && !pte_q.wr;

  assign lk_vpn  = va_q[VA_W-1:OFF_W];
  assign ins_vpn = va_q[VA_W-1:OFF_W];
  assign ins_pte = rd_pte;
  assign ins_en  = (state_q == ST_FETCH) && mem_ack && rd_pte.vld;
  assign upd_en  = (state_q == ST_CHECK) && !deny_page && !deny_wr && bits_change;
  assign upd_idx = idx_q;
  assign upd_pte = new_pte;

  assign req_ready   = (state_q == ST_IDLE);
  assign done        = (state_q == ST_RESP);
  assign done_paddr  = pa_q;
  assign fault_page  = done && fpg_q;
  assign fault_wprot = done && fwp_q;
  assign mem_req     = (state_q == ST_FETCH) || (state_q == ST_WBACK);
  assign mem_we      = (state_q == ST_WBACK);
  assign mem_addr    = entry_addr(pt_base, va_q[VA_W-1:OFF_W]);
  assign mem_wdata   = pte_q;
  assign st_busy     = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      st_q    <= 1'b0;
      pte_q   <= '0;
      idx_q   <= '0;
      pa_q    <= '0;
      fpg_q   <= 1'b0;
      fwp_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q    <= req_vaddr;
            st_q    <= req_store;
            fpg_q   <= 1'b0;
            fwp_q   <= 1'b0;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (lk_hit) begin
            pte_q   <= lk_pte;
            idx_q   <= lk_idx;
            state_q <= ST_CHECK;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            pte_q   <= rd_pte;
            idx_q   <= ins_idx;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (deny_page) begin
            fpg_q   <= 1'b1;
            pa_q    <= '0;
            state_q <= ST_RESP;
          end else if (deny_wr) begin
            fwp_q   <= 1'b1;
            pa_q    <= '0;
            state_q <= ST_RESP;
          end else begin
            pa_q    <= join_paddr(pte_q.frame, va_q[OFF_W-1:0]);
            pte_q   <= new_pte;
            state_q <= bits_change ? ST_WBACK : ST_RESP;
          end
        end
        ST_WBACK: begin
          if (mem_ack) state_q <= ST_RESP;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
  import xlate_pkg::*;
#(
  parameter int TLB_N = 4,
  localparam int IW = (TLB_N > 1) ? $clog2(TLB_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VA_W-1:0]  pt_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_store,
  output logic             done,
  output logic [VA_W-1:0]  done_paddr,
  output logic             fault_page,
  output logic             fault_wprot,
  output logic             mem_req,
  output logic             mem_we,
  output logic [VA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata
);
  logic [VPN_W-1:0] lk_vpn, ins_vpn;
  logic             lk_hit, ins_en, upd_en;
  logic [IW-1:0]    lk_idx, ins_idx, upd_idx;
  pte_t             lk_pte, ins_pte, upd_pte;
  logic [TLB_N-1:0] tlb_live;
  logic             wb_store;

  xlate_tlb #(.TLB_N(TLB_N)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pte(lk_pte),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_pte(ins_pte), .ins_idx(ins_idx),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_pte(upd_pte),
    .live(tlb_live)
  );

  xlate_ctrl #(.TLB_N(TLB_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store),
    .done(done), .done_paddr(done_paddr),
    .fault_page(fault_page), .fault_wprot(fault_wprot),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pte(lk_pte),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_pte(ins_pte), .ins_idx(ins_idx),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_pte(upd_pte),
    .st_busy(wb_store)
  );
endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int TLB_N = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             req_ready,
  input logic             done,
  input logic             fault_page,
  input logic             fault_wprot,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [31:0]      mem_addr,
  input logic [31:0]      mem_wdata,
  input logic [TLB_N-1:0] tlb_live,
  input logic             wb_store
);
  assert_fault_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_page || fault_wprot) |-> (done && !(fault_page && fault_wprot)));

  assert_busy_no_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!req_ready && !done));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tlb_live == '0));

  assert_wb_referenced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[2] && mem_wdata[0]));

  assert_wb_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && wb_store) |-> mem_wdata[3]);
endmodule

bind addr_xlate_unit xlate_checker #(.TLB_N(TLB_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_ready(req_ready),
  .done(done), .fault_page(fault_page), .fault_wprot(fault_wprot),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .tlb_live(tlb_live), .wb_store(wb_store)
);

// File: tb/addr_xlate_unit_tb.sv
module addr_xlate_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h8000_0000;
  localparam int NV = 16;

  typedef struct packed {
    logic [31:0] va;
    logic        st;
    logic [31:0] pa;
    logic [1:0]  flt;
    logic [1:0]  rd;
    logic [1:0]  wr;
  } vec_t;

  // flt: 0 none, 1 page fault, 2 protection fault
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0123, 1'b0, 32'h0001_0123, 2'd0, 2'd1, 2'd1},
    '{32'h0000_0456, 1'b0, 32'h0001_0456, 2'd0, 2'd0, 2'd0},
    '{32'h0000_0010, 1'b1, 32'h0001_0010, 2'd0, 2'd0, 2'd1},
    '{32'h0000_0020, 1'b1, 32'h0001_0020, 2'd0, 2'd0, 2'd0},
    '{32'h0000_1004, 1'b1, 32'h0000_0000, 2'd2, 2'd1, 2'd0},
    '{32'h0000_1008, 1'b0, 32'h0002_0008, 2'd0, 2'd0, 2'd1},
    '{32'h0000_2000, 1'b0, 32'h0000_0000, 2'd1, 2'd1, 2'd0},
    '{32'h0000_2000, 1'b0, 32'h0000_0000, 2'd1, 2'd1, 2'd0},
    '{32'h0000_3abc, 1'b0, 32'h0003_0abc, 2'd0, 2'd1, 2'd1},
    '{32'h0000_4001, 1'b0, 32'h0004_0001, 2'd0, 2'd1, 2'd1},
    '{32'h0000_5002, 1'b0, 32'h0005_0002, 2'd0, 2'd1, 2'd1},
    '{32'h0000_0ff0, 1'b0, 32'h0001_0ff0, 2'd0, 2'd1, 2'd0},
    '{32'h0000_3000, 1'b0, 32'h0003_0000, 2'd0, 2'd0, 2'd0},
    '{32'hffff_f123, 1'b0, 32'h0000_0000, 2'd1, 2'd1, 2'd0},
    '{32'h0000_1000, 1'b0, 32'h0002_0000, 2'd0, 2'd1, 2'd0},
    '{32'h0000_4abc, 1'b0, 32'h0004_0abc, 2'd0, 2'd0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic        req_ready, done, fault_page, fault_wprot;
  logic [31:0] done_paddr;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] pt [16];
  int n_rd = 0, n_wr = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0] got_pa;
  logic [1:0]  got_flt;
  int          got_rd, got_wr;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_xlate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(BASE),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store),
    .done(done), .done_paddr(done_paddr),
    .fault_page(fault_page), .fault_wprot(fault_wprot),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Memory model: one page table of 16 entries at BASE, the rest reads as zero.
  always @(negedge clk) begin
    logic [31:0] off;
    off = mem_addr - BASE;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) pt[i] = 32'h0;
      pt[0] = 32'h0001_0003;
      pt[1] = 32'h0002_0001;
      pt[3] = 32'h0003_0003;
      pt[4] = 32'h0004_0003;
      pt[5] = 32'h0005_0003;
      mem_ack <= 1'b0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        n_wr++;
        if (off < 32'd64) pt[off[5:2]] = mem_wdata;
      end else begin
        n_rd++;
        mem_rdata <= (off < 32'd64) ? pt[off[5:2]] : 32'h0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] va, input logic st);
    int rd0, wr0, guard;
    rd0 = n_rd;
    wr0 = n_wr;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 ready low while busy", {31'b0, req_ready}, 32'd0);
    guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    chk(done, "R10 request completes", {31'b0, done}, 32'd1);
    got_pa  = done_paddr;
    got_flt = {fault_wprot, fault_page};
    got_rd  = n_rd - rd0;
    got_wr  = n_wr - wr0;
    @(negedge clk);
    chk(!done, "R10 done is one cycle", {31'b0, done}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready, "R11 ready after reset", {31'b0, req_ready}, 32'd1);
    chk(!done && !mem_req, "R11 idle outputs", {30'b0, done, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      do_req(VEC[k].va, VEC[k].st);
      // R3 and R6: fault flags; R1: physical address
      chk(got_flt == VEC[k].flt, "R3/R6 fault code", {30'b0, got_flt}, {30'b0, VEC[k].flt});
      chk(got_pa == VEC[k].pa, "R1 physical address", got_pa, VEC[k].pa);
      // R2 and R8: table reads depend on cache contents and round-robin order
      chk(got_rd == int'(VEC[k].rd), "R2/R8 table reads", got_rd, {30'b0, VEC[k].rd});
      chk(got_wr == int'(VEC[k].wr), "R7 write-backs", got_wr, {30'b0, VEC[k].wr});
    end

    chk(pt[0] == 32'h0001_000f, "R5 store sets dirty", pt[0], 32'h0001_000f);
    chk(pt[1] == 32'h0002_0005, "R6 no dirty after protection fault", pt[1], 32'h0002_0005);
    chk(pt[3] == 32'h0003_0007, "R4 load sets referenced only", pt[3], 32'h0003_0007);
    chk(pt[2] == 32'h0, "R3 nonresident entry untouched", pt[2], 32'h0);

    // R9 flush then re-access a cached page
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    do_req(32'h0000_4010, 1'b0);
    chk(got_rd == 1, "R9 read after flush", got_rd, 32'd1);
    chk(got_pa == 32'h0004_0010, "R9 address after flush", got_pa, 32'h0004_0010);
    do_req(32'h0000_4014, 1'b1);
    chk(got_rd == 0 && got_wr == 1, "R5 store hit writes dirty", {got_rd[15:0], got_wr[15:0]},
        32'h0000_0001);
    chk(pt[4] == 32'h0004_000f, "R5 dirty in memory", pt[4], 32'h0004_000f);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule